// File: doc/BRIEF.md
# Register-Mapped Serial Port with Byte Queues

This block is a compact asynchronous serial port that a processor reaches through four 32-bit word registers on a plain strobe bus. The bus has an address, a write strobe with write data, and a read strobe with read data returned combinationally in the same cycle. Software queues bytes for sending by writing them into a transmit queue. A fixed-rate transmitter drains that queue onto the serial output line. A matching receiver samples the serial input line and stores each complete byte in a receive queue, where software picks it up.

A status word reports how full both queues are, whether the interrupt is enabled, and three sticky error flags. Reading the status word clears those flags. A control word empties either queue and switches the single interrupt line on or off. When enabled, the interrupt line carries two kinds of event. One is a level that stays high while received bytes are waiting. The other is a one-cycle pulse when the transmit queue runs dry. The bit period, queue depth and parity mode are fixed by parameters.

Top module: `lite_uart`

## Requirements
- R1: After reset the status word reads 0x04 (only the transmit-empty bit set), `irq` is low and `txd` idles high.
- R2: Each transmitted byte is sent in write order as one low start bit, eight data bits LSB first, an even parity bit (when `PARITY_EN` is 1), and one high stop bit. Each bit lasts `CLK_DIV` clocks.
- R3: The transmit queue holds `DEPTH` bytes, written at word offset 0x4. A write while it is full is dropped. Status bit 2 reports empty and bit 3 reports full.
- R4: A received frame puts its byte into the receive queue. A read at offset 0x0 returns the oldest byte in bits 7:0 and removes it. Status bit 0 means data is waiting and bit 1 means the receive queue is full.
- R5: A read at offset 0x0 while the receive queue is empty returns zero and changes no state.
- R6: A frame that completes while the receive queue is full is discarded and sets the sticky overrun flag, status bit 5.
- R7: A stop bit sampled low sets the sticky framing flag, bit 6. With parity enabled, a parity mismatch sets the sticky parity flag, bit 7. The byte is still stored in both cases.
- R8: A read of the status word at offset 0x8 returns bits 7:5 as they stood and then clears them. An error arriving in that same cycle is kept.
- R9: A write to the control word at offset 0xC with bit 0 set empties the transmit queue, and with bit 1 set empties the receive queue, both in one cycle. A frame already being sent completes.
- R10: Control bit 4 sets the interrupt enable, which reads back as status bit 4. Any control write without bit 4 clears it. With the enable clear, `irq` stays low.
- R11: With the enable set, `irq` is high for as long as the receive queue holds data.
- R12: With the enable set, `irq` pulses for exactly one clock when the transmit queue goes from holding data to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_rdata | output | 32 | Read data for the addressed register |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Combined interrupt |

## Verification
The transmit path is exercised with isolated bytes, with an 18-write burst that overfills the queue, and with a flush that lands mid-frame. These cases separate correct ordering, silent dropping and the completion of a frame already in flight. The receive path is fed clean frames, frames with a bad stop bit or bad parity, and a 17-frame burst with no reads. These cases separate stored data, each sticky flag and overrun discard. Interrupt behaviour is checked with the enable on and off, which separates the receive level from the one-cycle transmit-empty pulse.

// File: rtl/uls_pkg.sv
package uls_pkg;

    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    localparam int ST_RXV = 0;
    localparam int ST_RXF = 1;
    localparam int ST_TXE = 2;
    localparam int ST_TXF = 3;
    localparam int ST_IE  = 4;
    localparam int ST_OVR = 5;
    localparam int ST_FE  = 6;
    localparam int ST_PE  = 7;

    localparam int CT_TXCLR = 0;
    localparam int CT_RXCLR = 1;
    localparam int CT_IE    = 4;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_err;
        logic       parity_err;
    } rx_word_t;

    typedef struct packed {
        logic parity;
        logic framing;
        logic overrun;
    } err_flags_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_e;

    function automatic logic parity_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uls_fifo.sv
module uls_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/uls_tx.sv
module uls_tx
    import uls_pkg::*;
#(
    parameter int CLK_DIV    = 16,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0,
    localparam int NBITS     = (PARITY_EN != 0) ? 11 : 10,
    localparam int CNT_W     = $clog2(CLK_DIV)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       avail,
    input  logic [7:0] data,
    output logic       take,
    output logic       txd
);
    logic             busy;
    logic [10:0]      sh;
    logic [10:0]      frame;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       idx;

    assign take = ~busy & avail;
    assign txd  = busy ? sh[0] : 1'b1;

    always_comb begin
        frame = {1'b1,
                 (PARITY_EN != 0) ? parity_of(data, PARITY_ODD != 0) : 1'b1,
                 data, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            cnt  <= '0;
            idx  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sh   <= frame;
            cnt  <= '0;
            idx  <= '0;
        end else if (busy) begin
            if (cnt == CNT_W'(CLK_DIV - 1)) begin
                cnt <= '0;
                sh  <= {1'b1, sh[10:1]};
                if (idx == 4'(NBITS - 1)) busy <= 1'b0;
                else                      idx  <= idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);
    p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == 4'(NBITS - 1)) |-> txd);
endmodule

// File: rtl/uls_rx.sv
module uls_rx
    import uls_pkg::*;
#(
    parameter int CLK_DIV    = 16,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0,
    localparam int CNT_W     = $clog2(CLK_DIV),
    localparam int HALF      = CLK_DIV / 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rxd,
    output logic     done,
    output rx_word_t word
);
    logic [1:0]       sy;
    logic             rxs;
    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             pbit;
    logic             last;

    assign rxs  = sy[1];
    assign last = (cnt == CNT_W'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sy   <= 2'b11;
            st   <= RX_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            done <= 1'b0;
            word <= '0;
        end else begin
            sy   <= {sy[0], rxd};
            done <= 1'b0;
            case (st)
                RX_IDLE: if (!rxs) begin
                    st  <= RX_START;
                    cnt <= '0;
                end
                RX_START: if (cnt == CNT_W'(HALF - 1)) begin
                    cnt  <= '0;
                    bitn <= '0;
                    st   <= rxs ? RX_IDLE : RX_DATA;
                end else cnt <= cnt + 1'b1;
                RX_DATA: if (last) begin
                    cnt <= '0;
                    sh  <= {rxs, sh[7:1]};
                    if (bitn == 3'd7) st <= (PARITY_EN != 0) ? RX_PAR : RX_STOP;
                    else              bitn <= bitn + 1'b1;
                end else cnt <= cnt + 1'b1;
                RX_PAR: if (last) begin
                    cnt  <= '0;
                    pbit <= rxs;
                    st   <= RX_STOP;
                end else cnt <= cnt + 1'b1;
                RX_STOP: if (last) begin
                    cnt             <= '0;
                    st              <= rxs ? RX_IDLE : RX_HOLD;
                    done            <= 1'b1;
                    word.data       <= sh;
                    word.frame_err  <= ~rxs;
                    word.parity_err <= (PARITY_EN != 0) &&
                                       (pbit != parity_of(sh, PARITY_ODD != 0));
                end else cnt <= cnt + 1'b1;
                RX_HOLD: if (rxs) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/lite_uart.sv
module lite_uart
    import uls_pkg::*;
#(
    parameter int CLK_DIV    = 16,
    parameter int DEPTH      = 16,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq
);
    reg_sel_e   sel;
    logic       wr_tx, wr_ctrl, rd_rx, rd_stat;
    logic       tx_flush, rx_flush;
    logic       tx_empty, tx_full, tx_take, tx_empty_q, tx_evt;
    logic [7:0] tx_head, rx_head;
    logic       rx_empty, rx_full, rx_done;
    logic [CW-1:0] tx_count, rx_count;
    rx_word_t   rx_word;
    logic       ie;
    err_flags_t err, err_set;
    logic [7:0] status;
    logic       unused_ok;

    assign sel      = reg_sel_e'(bus_addr[3:2]);
    assign wr_tx    = bus_wr & (sel == REG_TXD);
    assign wr_ctrl  = bus_wr & (sel == REG_CTRL);
    assign rd_rx    = bus_rd & (sel == REG_RXD);
    assign rd_stat  = bus_rd & (sel == REG_STAT);
    assign tx_flush = wr_ctrl & bus_wdata[CT_TXCLR];
    assign rx_flush = wr_ctrl & bus_wdata[CT_RXCLR];
    assign unused_ok = ^{bus_addr[1:0], bus_wdata[31:8], tx_count};

    uls_fifo #(.W(8), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst(rst), .flush(tx_flush), .push(wr_tx),
        .wdata(bus_wdata[7:0]), .pop(tx_take), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .count(tx_count));

    uls_tx #(.CLK_DIV(CLK_DIV), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) i_tx (
        .clk(clk), .rst(rst), .avail(~tx_empty), .data(tx_head),
        .take(tx_take), .txd(txd));

    uls_rx #(.CLK_DIV(CLK_DIV), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) i_rx (
        .clk(clk), .rst(rst), .rxd(rxd), .done(rx_done), .word(rx_word));

    uls_fifo #(.W(8), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_done),
        .wdata(rx_word.data), .pop(rd_rx), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_count));

    always_comb begin
        err_set.overrun = rx_done & rx_full;
        err_set.framing = rx_done & rx_word.frame_err;
        err_set.parity  = rx_done & rx_word.parity_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie         <= 1'b0;
            err        <= '0;
            tx_empty_q <= 1'b1;
        end else begin
            if (wr_ctrl) ie <= bus_wdata[CT_IE];
            err        <= err_flags_t'((rd_stat ? 3'b000 : err) | err_set);
            tx_empty_q <= tx_empty;
        end
    end

    assign tx_evt = tx_empty & ~tx_empty_q;
    assign irq    = ie & (~rx_empty | tx_evt);

    always_comb begin
        status         = '0;
        status[ST_RXV] = ~rx_empty;
        status[ST_RXF] = rx_full;
        status[ST_TXE] = tx_empty;
        status[ST_TXF] = tx_full;
        status[ST_IE]  = ie;
        status[ST_OVR] = err.overrun;
        status[ST_FE]  = err.framing;
        status[ST_PE]  = err.parity;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_RXD:  if (!rx_empty) bus_rdata[7:0] = rx_head;
            REG_STAT: bus_rdata[7:0] = status;
            default:  bus_rdata = '0;
        endcase
    end

    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rx_done) |=> (err == '0));
    p_sticky_ovr_r6: assert property (@(posedge clk) disable iff (rst)
        (err.overrun && !rd_stat) |=> err.overrun);
    p_rx_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !rx_empty && !rx_done && !rx_flush) |=> rx_count == $past(rx_count) - 1'b1);
    p_ie_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ie == $past(bus_wdata[CT_IE]));
    p_tx_evt_single_r12: assert property (@(posedge clk) disable iff (rst)
        tx_evt |=> !tx_evt);
endmodule

// File: tb/test_lite_uart.sv
module test_lite_uart;
    localparam int CLK_DIV = 16;
    localparam int DEPTH   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int frames = 0;
    int irq_cnt = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic m_ovr = 0, m_fe = 0, m_pe = 0, m_ie = 0;

    always #2 clk = ~clk;

    lite_uart #(.CLK_DIV(CLK_DIV), .DEPTH(DEPTH)) i_lite_uart (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        if (a == 4'h4) begin
            if (txq.size() < DEPTH) txq.push_back(d[7:0]);
        end else if (a == 4'hC) begin
            m_ie = d[4];
            if (d[0]) txq.delete();
            if (d[1]) rxq.delete();
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_status(input string req);
        logic [31:0] d;
        logic [7:0]  e;
        bread(4'h8, d);
        e = {m_pe, m_fe, m_ovr, m_ie, txq.size() == DEPTH, txq.size() == 0,
             rxq.size() == DEPTH, rxq.size() != 0};
        check(d == {24'h0, e}, req, d, {24'h0, e});
        m_pe = 0; m_fe = 0; m_ovr = 0;
    endtask

    task automatic chk_rx(input string req);
        logic [31:0] d;
        logic [7:0]  e;
        bread(4'h0, d);
        e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
        check(d == {24'h0, e}, req, d, {24'h0, e});
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (CLK_DIV) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit((^b) ^ bad_par);
        drive_bit(!bad_stop);
        drive_bit(1'b1);
        if (rxq.size() < DEPTH) rxq.push_back(b);
        else m_ovr = 1;
        if (bad_stop) m_fe = 1;
        if (bad_par)  m_pe = 1;
    endtask

    task automatic wait_tx_idle();
        while (txq.size() != 0) @(negedge clk);
        repeat (CLK_DIV * 13) @(negedge clk);
    endtask

    // serial output monitor: decodes each frame and compares with the model queue (R2)
    initial begin
        logic [7:0] got, exp;
        bit had, okf;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                had = (txq.size() != 0);
                exp = had ? txq.pop_front() : 8'h00;
                repeat (CLK_DIV / 2) @(negedge clk);
                okf = (txd == 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CLK_DIV) @(negedge clk);
                    got[i] = txd;
                end
                repeat (CLK_DIV) @(negedge clk);
                okf = okf && (txd == ^got);
                repeat (CLK_DIV) @(negedge clk);
                okf = okf && (txd == 1'b1);
                frames++;
                check(had && okf && got == exp, "R2 frame", {23'h0, okf, got}, {23'h1, exp});
            end
        end
    end

    always @(negedge clk) if (irq === 1'b1) irq_cnt++;

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(txd == 1'b1, "R1 txd", txd, 1);
        chk_status("R1 status");

        // R10: enable clear, no interrupt from transmit
        irq_cnt = 0;
        bwrite(4'h4, 32'hA5);
        bwrite(4'h4, 32'h3C);
        wait_tx_idle();
        check(irq_cnt == 0, "R10 irq disabled", irq_cnt, 0);

        bwrite(4'hC, 32'h10);
        chk_status("R10 enable readback");
        irq_cnt = 0;
        bwrite(4'h4, 32'h5A);
        wait_tx_idle();
        check(irq_cnt == 1, "R12 single pulse", irq_cnt, 1);
        bwrite(4'hC, 32'h00);
        chk_status("R10 disable readback");

        // R3: overfill the transmit queue
        for (int i = 0; i < 18; i++) bwrite(4'h4, 32'h10 + i);
        chk_status("R3 full");
        wait_tx_idle();
        chk_status("R3 empty");

        // R4, R11, R5
        bwrite(4'hC, 32'h10);
        send_rx(8'h81, 0, 0);
        chk_status("R4 valid");
        check(irq == 1'b1, "R11 level", irq, 1);
        chk_rx("R4 data");
        check(irq == 1'b0, "R11 drop", irq, 0);
        chk_rx("R5 empty read");
        chk_status("R5 no pop");

        // R7, R8
        send_rx(8'h3C, 0, 1);
        chk_status("R7 framing");
        chk_status("R8 cleared");
        send_rx(8'hC3, 1, 0);
        chk_status("R7 parity");
        chk_status("R8 cleared");
        chk_rx("R7 byte kept");
        chk_rx("R7 byte kept");

        // R6: overrun
        for (int i = 0; i < 17; i++) send_rx(8'h40 + 8'(i), 0, 0);
        chk_status("R6 overrun");
        chk_status("R8 overrun cleared");
        for (int i = 0; i < 16; i++) chk_rx("R6 order");
        chk_status("R6 drained");

        // R9: receive flush
        send_rx(8'h11, 0, 0);
        send_rx(8'h22, 0, 0);
        bwrite(4'hC, 32'h12);
        chk_status("R9 rx flush");
        check(irq == 1'b0, "R11 after flush", irq, 0);

        // R9: transmit flush mid-frame
        bwrite(4'hC, 32'h00);
        for (int i = 0; i < 4; i++) bwrite(4'h4, 32'hE0 + i);
        repeat (40) @(negedge clk);
        bwrite(4'hC, 32'h01);
        chk_status("R9 tx flush");
        wait_tx_idle();
        check(frames == 21, "R9 frame total", frames, 21);

        finish_run();
    end
endmodule